// File: doc/BRIEF.md
# Slave SPI Byte Port with Idle Filling

This block is the host-facing side of a serial link in which an external master owns the clock. The master polls the slave over SPI mode 1 (clock idle low, launch on the rising edge, sample on the falling edge, chip select active low). Internal logic pushes outgoing bytes into a transmit FIFO and pops incoming bytes from a receive FIFO. All three SPI inputs are brought into the system clock domain through synchronizer flops, and the edges are detected there. The system clock must therefore run several times faster than SCK.

The master can clock the slave at any time. When no outgoing data is queued, the slave fills each byte slot from an alternating two-byte pattern, 0xA7 and then 0xB4. The master sends the same pattern when it has nothing to say, so the slave drops that pattern from the received stream. No framing is needed on either side.

An interrupt output is high while nothing remains to send. The port has two sticky flags. A framing fault freezes the port until internal logic clears it. A receive overflow drops the incoming byte.

Top module: `spi_idle_port`

## Requirements
- R1: After reset, miso_o is 0, rx_empty_o is 1, tx_full_o is 0, drain_irq_o is 1, and sync_err_o and rx_ovf_o are both 0.
- R2: Bytes written through tx_push_i leave on MISO in the order they were written, MSB first. The first bit is driven after the first rising SCK edge of the byte, and the following bits after each later rising edge.
- R3: If the transmit FIFO is empty when a byte starts, the slave sends the next idle byte. The idle bytes alternate 0xA7, 0xB4, 0xA7, and so on. Only idle bytes advance this sequence. Every chip-select assertion restarts it at 0xA7.
- R4: MOSI is sampled on each falling SCK edge, MSB first. After the eighth falling edge, the completed byte is offered to the receive FIFO, which presents its oldest byte on rx_data_o while rx_empty_o is 0.
- R5: The receive filter keeps its own idle phase, which is either 0xA7 or 0xB4. It behaves as follows:
  - A completed byte that equals the byte of the current phase is discarded, and the phase flips.
  - Any other byte is stored, and the phase returns to 0xA7.
  - Every chip-select assertion sets the phase to 0xA7.
- R6: drain_irq_o is 1 exactly when the transmit FIFO is empty and the shift register holds no FIFO byte. It is 0 while the last queued byte is being shifted out, and it returns to 1 after that byte's eighth falling edge.
- R7: If chip select deasserts after a byte's first rising edge and before its eighth falling edge, sync_err_o is set. The flag stays set until err_clr_i. While it is set, miso_o stays 0, nothing is stored, and nothing is taken from the transmit FIFO.
- R8: A non-idle byte that completes while the receive FIFO is full is dropped, and rx_ovf_o is set. The flag stays set until err_clr_i. The bytes already stored are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | SPI clock from master |
| csn_i | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Serial data from master |
| miso_o | output | 1 | Serial data to master |
| tx_data_i | input | 8 | Byte to queue for transmission |
| tx_push_i | input | 1 | Write tx_data_i into the transmit FIFO |
| tx_full_o | output | 1 | Transmit FIFO full |
| rx_data_o | output | 8 | Oldest received byte |
| rx_pop_i | input | 1 | Remove the oldest received byte |
| rx_empty_o | output | 1 | Receive FIFO empty |
| drain_irq_o | output | 1 | All transmit data has drained |
| sync_err_o | output | 1 | Sticky framing-fault flag |
| rx_ovf_o | output | 1 | Sticky receive-overflow flag |
| err_clr_i | input | 1 | Clear both sticky flags |

## Verification
The hardest states to reach are a chip-select release in the middle of a byte and a receive FIFO that is already full when a byte completes.

For the first, the bench's master task stops after three bits and raises chip select. It then runs a full byte while the fault is pending and checks that MISO stays quiet, that nothing is stored and that the queued transmit byte is kept.

For the second, the bench sets the receive depth to four and sends five non-idle bytes in one session.

The idle filter is exercised with streams in which the pattern bytes appear in order, out of order and across a chip-select boundary.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
    localparam logic [7:0] IDLE_FIRST  = 8'hA7;
    localparam logic [7:0] IDLE_SECOND = 8'hB4;

    typedef enum logic {PH_FIRST = 1'b0, PH_SECOND = 1'b1} idle_phase_e;

    typedef struct packed {
        logic sck_rise;
        logic sck_fall;
        logic cs_active;
        logic cs_start;
        logic cs_end;
        logic mosi;
    } pin_events_t;

    function automatic logic [7:0] idle_byte(idle_phase_e ph);
        return (ph == PH_FIRST) ? IDLE_FIRST : IDLE_SECOND;
    endfunction

    function automatic idle_phase_e next_phase(idle_phase_e ph);
        return (ph == PH_FIRST) ? PH_SECOND : PH_FIRST;
    endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync
    import spi_port_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sck_i,
    input  logic        csn_i,
    input  logic        mosi_i,
    output pin_events_t ev_o
);
    // bit order in each stage: {sck, csn, mosi}; idle levels sck=0, csn=1
    localparam logic [2:0] IDLE_LEVELS = 3'b010;

    logic [2:0] stage_q [STAGES];
    logic [2:0] prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[g] <= IDLE_LEVELS;
                end else if (g == 0) begin
                    stage_q[g] <= {sck_i, csn_i, mosi_i};
                end else begin
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= IDLE_LEVELS;
        else     prev_q <= stage_q[STAGES-1];
    end

    logic [2:0] cur;
    assign cur = stage_q[STAGES-1];

    always_comb begin
        ev_o.sck_rise  = cur[2] & ~prev_q[2];
        ev_o.sck_fall  = ~cur[2] & prev_q[2];
        ev_o.cs_active = ~cur[1];
        ev_o.cs_start  = ~cur[1] & prev_q[1];
        ev_o.cs_end    = cur[1] & ~prev_q[1];
        ev_o.mosi      = cur[0];
    end
endmodule

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [AW:0]      count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == (AW+1)'(DEPTH));
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign rdata   = mem[rptr];

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  pin_events_t ev,
    input  logic        tx_empty,
    input  logic [7:0]  tx_rdata,
    output logic        tx_pop,
    input  logic        rx_full,
    output logic        rx_push,
    output logic [7:0]  rx_wdata,
    input  logic        err_clr,
    output logic        miso,
    output logic        data_held,
    output logic        sync_err,
    output logic        rx_ovf
);
    logic [7:0]  tx_sr, rx_sr;
    logic [2:0]  bit_cnt;
    logic        in_byte;
    idle_phase_e tx_ph, rx_ph;

    logic        err_hit, run, byte_start, byte_done, is_idle;
    logic [7:0]  rx_next;

    assign err_hit    = ev.cs_end & in_byte & ~sync_err;
    assign run        = ~sync_err & ~err_hit & ev.cs_active;
    assign byte_start = run & ev.sck_rise & ~in_byte;
    assign byte_done  = run & ev.sck_fall & in_byte & (bit_cnt == 3'd7);
    assign rx_next    = {rx_sr[6:0], ev.mosi};
    assign is_idle    = (rx_next == idle_byte(rx_ph));

    assign tx_pop   = byte_start & ~tx_empty;
    assign rx_push  = byte_done & ~is_idle & ~rx_full;
    assign rx_wdata = rx_next;
    assign miso     = tx_sr[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_err <= 1'b0;
            rx_ovf   <= 1'b0;
        end else begin
            if (err_hit)      sync_err <= 1'b1;
            else if (err_clr) sync_err <= 1'b0;
            if (byte_done && !is_idle && rx_full) rx_ovf <= 1'b1;
            else if (err_clr)                     rx_ovf <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            tx_sr     <= '0;
            rx_sr     <= '0;
            bit_cnt   <= '0;
            in_byte   <= 1'b0;
            data_held <= 1'b0;
        end else begin
            if (byte_start) begin
                tx_sr     <= tx_empty ? idle_byte(tx_ph) : tx_rdata;
                data_held <= ~tx_empty;
                in_byte   <= 1'b1;
            end else if (ev.sck_rise) begin
                tx_sr <= {tx_sr[6:0], 1'b0};
            end
            if (ev.sck_fall && in_byte) begin
                rx_sr   <= rx_next;
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == 3'd7) begin
                    in_byte   <= 1'b0;
                    data_held <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_ph <= PH_FIRST;
            rx_ph <= PH_FIRST;
        end else if (ev.cs_start) begin
            tx_ph <= PH_FIRST;
            rx_ph <= PH_FIRST;
        end else begin
            if (byte_start && tx_empty) tx_ph <= next_phase(tx_ph);
            if (byte_done) rx_ph <= is_idle ? next_phase(rx_ph) : PH_FIRST;
        end
    end
endmodule

// File: rtl/spi_idle_port.sv
module spi_idle_port
    import spi_port_pkg::*;
#(
    parameter int TX_DEPTH    = 1024,
    parameter int RX_DEPTH    = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sck_i,
    input  logic       csn_i,
    input  logic       mosi_i,
    output logic       miso_o,
    input  logic [7:0] tx_data_i,
    input  logic       tx_push_i,
    output logic       tx_full_o,
    output logic [7:0] rx_data_o,
    input  logic       rx_pop_i,
    output logic       rx_empty_o,
    output logic       drain_irq_o,
    output logic       sync_err_o,
    output logic       rx_ovf_o,
    input  logic       err_clr_i
);
    pin_events_t ev;
    logic        tx_empty, tx_pop, rx_full, rx_push, data_held;
    logic [7:0]  tx_rdata, rx_wdata;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .sck_i(sck_i), .csn_i(csn_i), .mosi_i(mosi_i), .ev_o(ev)
    );

    spi_byte_fifo #(.DEPTH(TX_DEPTH), .WIDTH(8)) u_tx_fifo (
        .clk(clk), .rst(rst), .push(tx_push_i), .wdata(tx_data_i), .pop(tx_pop),
        .rdata(tx_rdata), .empty(tx_empty), .full(tx_full_o)
    );

    spi_byte_fifo #(.DEPTH(RX_DEPTH), .WIDTH(8)) u_rx_fifo (
        .clk(clk), .rst(rst), .push(rx_push), .wdata(rx_wdata), .pop(rx_pop_i),
        .rdata(rx_data_o), .empty(rx_empty_o), .full(rx_full)
    );

    spi_shift_engine u_engine (
        .clk(clk), .rst(rst), .ev(ev),
        .tx_empty(tx_empty), .tx_rdata(tx_rdata), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_wdata(rx_wdata),
        .err_clr(err_clr_i), .miso(miso_o), .data_held(data_held),
        .sync_err(sync_err_o), .rx_ovf(rx_ovf_o)
    );

    assign drain_irq_o = tx_empty & ~data_held;
endmodule

// File: rtl/spi_idle_port_chk.sv
module spi_idle_port_chk (
    input logic clk,
    input logic rst,
    input logic sync_err_o,
    input logic rx_ovf_o,
    input logic err_clr_i,
    input logic miso_o,
    input logic drain_irq_o,
    input logic tx_pop,
    input logic rx_push,
    input logic rx_full
);
    // R7: the fault flag holds until it is cleared
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (sync_err_o && !err_clr_i) |=> sync_err_o);

    // R7: a frozen port stores nothing, takes nothing and keeps MISO low
    p_err_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        sync_err_o |-> (!rx_push && !tx_pop && !miso_o));

    // R8: the overflow flag holds until it is cleared
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_ovf_o && !err_clr_i) |=> rx_ovf_o);

    // R8: nothing is written into a full receive FIFO
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        rx_push |-> !rx_full);

    // R6: a byte popped for sending keeps the interrupt low on the next cycle
    p_irq_low_after_pop_r6: assert property (@(posedge clk) disable iff (rst)
        tx_pop |=> !drain_irq_o);
endmodule

bind spi_idle_port spi_idle_port_chk u_chk (
    .clk(clk), .rst(rst), .sync_err_o(sync_err_o), .rx_ovf_o(rx_ovf_o),
    .err_clr_i(err_clr_i), .miso_o(miso_o), .drain_irq_o(drain_irq_o),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_full(rx_full)
);

// File: tb/test_spi_idle_port.sv
module test_spi_idle_port;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sck = 1'b0, csn = 1'b1, mosi = 1'b0;
    logic       miso;
    logic [7:0] tx_data = '0;
    logic       tx_push = 1'b0, tx_full;
    logic [7:0] rx_data;
    logic       rx_pop = 1'b0, rx_empty;
    logic       irq, sync_err, rx_ovf;
    logic       err_clr = 1'b0;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic mid_irq;
    logic [7:0] rx_exp [$];

    always #10 clk = ~clk;

    spi_idle_port #(.TX_DEPTH(4), .RX_DEPTH(4)) i_spi_idle_port (
        .clk(clk), .rst(rst), .sck_i(sck), .csn_i(csn), .mosi_i(mosi), .miso_o(miso),
        .tx_data_i(tx_data), .tx_push_i(tx_push), .tx_full_o(tx_full),
        .rx_data_o(rx_data), .rx_pop_i(rx_pop), .rx_empty_o(rx_empty),
        .drain_irq_o(irq), .sync_err_o(sync_err), .rx_ovf_o(rx_ovf), .err_clr_i(err_clr)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_low();
        csn = 1'b0;
        wclk(HALF);
    endtask

    task automatic cs_high();
        wclk(HALF);
        csn = 1'b1;
        wclk(2*HALF);
    endtask

    task automatic spi_bits(input logic [7:0] out, input int nbits, output logic [7:0] got);
        got = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = out[i];
            sck  = 1'b1;
            wclk(HALF);
            got[i] = miso;
            if (i == 4) mid_irq = irq;
            sck = 1'b0;
            wclk(HALF);
        end
    endtask

    task automatic spi_byte(input string req, input logic [7:0] out, input logic [7:0] exp_miso);
        logic [7:0] got;
        spi_bits(out, 8, got);
        chk(req, got, exp_miso);
    endtask

    task automatic push_tx(input logic [7:0] b);
        tx_data = b;
        tx_push = 1'b1;
        wclk(1);
        tx_push = 1'b0;
    endtask

    // scoreboard monitor: pop the oldest stored byte and compare with the queue head
    task automatic pop_check(input string req);
        logic [7:0] e;
        e = rx_exp.pop_front();
        chk({req, " rx_empty"}, rx_empty, 0);
        chk(req, rx_data, e);
        rx_pop = 1'b1;
        wclk(1);
        rx_pop = 1'b0;
        wclk(1);
    endtask

    task automatic pulse_clr();
        err_clr = 1'b1;
        wclk(1);
        err_clr = 1'b0;
        wclk(1);
    endtask

    initial begin
        logic [7:0] junk;
        wclk(4);
        rst = 1'b0;
        wclk(4);
        // R1 reset state
        chk("R1 miso", miso, 0);
        chk("R1 rx_empty", rx_empty, 1);
        chk("R1 tx_full", tx_full, 0);
        chk("R1 irq", irq, 1);
        chk("R1 sync_err", sync_err, 0);
        chk("R1 rx_ovf", rx_ovf, 0);

        // R3 idle fill, R5 idle stream discarded
        cs_low();
        spi_byte("R3 idle 1", 8'hA7, 8'hA7);
        spi_byte("R3 idle 2", 8'hB4, 8'hB4);
        spi_byte("R3 idle 3", 8'hA7, 8'hA7);
        cs_high();
        chk("R5 idle dropped", rx_empty, 1);

        // R2 data order, R6 drain interrupt, R3 phase untouched by data, R4/R5 filter
        push_tx(8'h3C);
        push_tx(8'h81);
        wclk(2);
        chk("R6 irq low when queued", irq, 0);
        cs_low();
        spi_byte("R2 byte 1", 8'h11, 8'h3C);
        rx_exp.push_back(8'h11);
        spi_byte("R2 byte 2", 8'hA7, 8'h81);
        chk("R6 irq low while last byte shifts", mid_irq, 0);
        chk("R6 irq high after drain", irq, 1);
        spi_byte("R3 idle after data", 8'h22, 8'hA7);
        rx_exp.push_back(8'h22);
        spi_byte("R3 idle second", 8'hB4, 8'hB4);
        rx_exp.push_back(8'hB4);
        cs_high();
        pop_check("R4 first stored");
        pop_check("R5 lone A7 dropped, 22 kept");
        pop_check("R5 B4 out of phase kept");
        chk("R4 rx empty after pops", rx_empty, 1);

        // R3 and R5 phase restart on chip select
        cs_low();
        spi_byte("R3 session A", 8'hA7, 8'hA7);
        cs_high();
        cs_low();
        spi_byte("R3 phase restart", 8'hB4, 8'hA7);
        rx_exp.push_back(8'hB4);
        cs_high();
        pop_check("R5 phase restart keeps B4");

        // R7 synchronization error
        cs_low();
        spi_bits(8'hFF, 3, junk);
        csn = 1'b1;
        wclk(2*HALF);
        chk("R7 sync_err set", sync_err, 1);
        push_tx(8'h55);
        cs_low();
        spi_byte("R7 miso quiet", 8'h77, 8'h00);
        cs_high();
        chk("R7 nothing stored", rx_empty, 1);
        chk("R7 tx byte kept", irq, 0);
        chk("R7 flag still set", sync_err, 1);
        pulse_clr();
        chk("R7 flag cleared", sync_err, 0);
        cs_low();
        spi_byte("R7 resume send", 8'h66, 8'h55);
        rx_exp.push_back(8'h66);
        cs_high();
        pop_check("R7 resume receive");

        // R8 overflow
        cs_low();
        for (int k = 1; k <= 5; k++) begin
            spi_byte("R8 fill", 8'(k), (k % 2 == 1) ? 8'hA7 : 8'hB4);
            if (k <= 4) rx_exp.push_back(8'(k));
        end
        cs_high();
        chk("R8 ovf set", rx_ovf, 1);
        for (int k = 1; k <= 4; k++) pop_check("R8 stored bytes intact");
        chk("R8 fifth dropped", rx_empty, 1);
        pulse_clr();
        chk("R8 ovf cleared", rx_ovf, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog: actual=timeout expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule